// File: doc/BRIEF.md
# Motion-Compensation Reference Fetch Planner

This block sits between a motion-vector source and an external SDRAM read port in a video decoder. It takes one 4×4 luma partition at a time, given as the integer part of the motion vector (a signed pixel position in the reference picture) and the two-bit fractional parts in each direction. From the fractional bits it picks one of four window shapes. It places the window so that the six-tap interpolation filter has its taps. Any part of the window outside the picture is clamped to the edge. The block then issues one read request per distinct picture line of the clamped window.

Each request carries an SDRAM row, a column and a burst length in bus beats. Every beat holds eight 8-bit pixels. A fixed band of picture lines shares one SDRAM row. Lines are requested in ascending order, so all accesses to one row are grouped together and a block never opens more than two rows. The window height and width are reported to the downstream interpolator for as long as the block is being fetched. A one-cycle done pulse follows the last accepted request. In that same cycle the planner is already free to take the next partition.

Top module: `mcFetchPlanner`

## Requirements
- R1: While reset is asserted and right after it is released, blkReady is 1, reqValid is 0, done is 0, and the reported window is 4 rows by 4 columns.
- R2: From the cycle after a block is accepted, winRows/winCols report the shape. Both fractional parts zero gives 4×4. A nonzero horizontal fraction only gives 4 rows × 9 columns. A nonzero vertical fraction only gives 9 rows × 4 columns. Both nonzero gives 9×9.
- R3: In a filtered direction (nonzero fraction) the window starts 2 pixels before the integer position and spans 9 pixels. In an unfiltered direction it starts at the integer position and spans 4 pixels.
- R4: The window's first and last coordinates are each clamped to [0, PIC_W-1] horizontally and [0, PIC_H-1] vertically. Only the lines between the clamped first and last line are requested, each exactly once.
- R5: For picture line y, a request carries reqRow = y >> BAND_LOG2 and reqCol = (y mod 2^BAND_LOG2)·(PIC_W/8) + floor(xLo/8). It carries reqBurst = floor(xHi/8) − floor(xLo/8) + 1, where xLo/xHi are the clamped horizontal limits.
- R6: Lines are requested in ascending order. reqRow never decreases within a block and changes at most once per block.
- R7: While reqValid is 1 and reqReady is 0, reqValid stays 1 and reqRow, reqCol and reqBurst hold their values.
- R8: blkReady is 0 from the cycle after acceptance until the last request handshake. done is a one-cycle pulse in the cycle after that handshake. A block offered in that same cycle is accepted.
- R9: The number of requests for a block equals clamped last line − clamped first line + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkValid | input | 1 | A partition is offered |
| blkReady | output | 1 | Planner can accept a partition |
| intX | input | COORD_W | Signed integer horizontal position |
| intY | input | COORD_W | Signed integer vertical position |
| fracX | input | 2 | Horizontal fractional motion bits |
| fracY | input | 2 | Vertical fractional motion bits |
| reqValid | output | 1 | A read request is presented |
| reqReady | input | 1 | Memory side takes the request |
| reqRow | output | ROW_W | SDRAM row of the request |
| reqCol | output | COL_W | SDRAM column (beat index) of the request |
| reqBurst | output | 4 | Burst length in 64-bit beats |
| winRows | output | 4 | Window height for the interpolator |
| winCols | output | 4 | Window width for the interpolator |
| done | output | 1 | Pulse after the last request of a block |

## Verification
The done pulse for one block and the acceptance of the next block fall in the same cycle. The bench provokes this by presenting every new partition right at the clock edge after the previous block's final handshake, with no idle gap. In that one cycle it checks that done is high and blkReady is high. After the edge it checks that done has dropped, blkReady is low, and the new block's first request appears with its own expected fields. Memory-side stalls are mixed in on alternate vectors, so the final handshake sometimes follows a held request.

// File: rtl/mcFetchPkg.sv
package mcFetchPkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    SHAPE_FULL = 2'd0,
    SHAPE_HORZ = 2'd1,
    SHAPE_VERT = 2'd2,
    SHAPE_BOTH = 2'd3
  } winShape_t;
endpackage

// File: rtl/mcFetchPath.sv
module mcFetchPath
  import mcFetchPkg::*;
#(
  parameter int PIC_W     = 1920,
  parameter int PIC_H     = 1088,
  parameter int COORD_W   = 12,
  parameter int BUS_W     = 64,
  parameter int BAND_LOG2 = 4,
  parameter int ROW_W     = COORD_W - BAND_LOG2,
  parameter int COL_W     = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic signed [COORD_W-1:0] intX,
  input  logic signed [COORD_W-1:0] intY,
  input  logic [1:0]                fracX,
  input  logic [1:0]                fracY,
  output logic                      lineLast,
  output logic [ROW_W-1:0]          reqRow,
  output logic [COL_W-1:0]          reqCol,
  output logic [3:0]                reqBurst,
  output logic [3:0]                winRows,
  output logic [3:0]                winCols
);
  localparam int PIX_LOG2   = $clog2(BUS_W / 8);
  localparam int BEATS_LINE = PIC_W >> PIX_LOG2;
  localparam int FILT_SPAN  = 9;
  localparam int PLAIN_SPAN = 4;
  localparam int LEAD_TAPS  = 2;

  function automatic logic [COORD_W-1:0] clampTo(input logic signed [COORD_W-1:0] v,
                                                 input int lim);
    if (v < 0) return '0;
    else if (int'(v) > lim - 1) return COORD_W'(lim - 1);
    else return v;
  endfunction

  winShape_t shape;
  logic signed [COORD_W-1:0] x0, x1, y0, y1;
  logic [COORD_W-1:0] xLo, xHi, yLo, yHi;
  logic [COORD_W-1:0] beatLo, beatHi;
  logic [COORD_W-1:0] beatBase, lineCur, lineEnd;
  logic [3:0] spanX, spanY;

  always_comb begin
    shape = winShape_t'({fracY != 2'd0, fracX != 2'd0});
    case (shape)
      SHAPE_FULL: begin spanX = 4'(PLAIN_SPAN); spanY = 4'(PLAIN_SPAN); end
      SHAPE_HORZ: begin spanX = 4'(FILT_SPAN);  spanY = 4'(PLAIN_SPAN); end
      SHAPE_VERT: begin spanX = 4'(PLAIN_SPAN); spanY = 4'(FILT_SPAN);  end
      default:    begin spanX = 4'(FILT_SPAN);  spanY = 4'(FILT_SPAN);  end
    endcase
    x0 = (spanX == 4'(FILT_SPAN)) ? intX - COORD_W'(LEAD_TAPS) : intX;
    y0 = (spanY == 4'(FILT_SPAN)) ? intY - COORD_W'(LEAD_TAPS) : intY;
    x1 = x0 + COORD_W'(spanX) - COORD_W'(1);
    y1 = y0 + COORD_W'(spanY) - COORD_W'(1);
    xLo = clampTo(x0, PIC_W);
    xHi = clampTo(x1, PIC_W);
    yLo = clampTo(y0, PIC_H);
    yHi = clampTo(y1, PIC_H);
    beatLo = xLo >> PIX_LOG2;
    beatHi = xHi >> PIX_LOG2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatBase <= '0;
      lineCur  <= '0;
      lineEnd  <= '0;
      reqBurst <= 4'd1;
      winRows  <= 4'(PLAIN_SPAN);
      winCols  <= 4'(PLAIN_SPAN);
    end else if (strobe.load) begin
      beatBase <= beatLo;
      lineCur  <= yLo;
      lineEnd  <= yHi;
      reqBurst <= 4'(beatHi - beatLo + COORD_W'(1));
      winRows  <= spanY;
      winCols  <= spanX;
    end else if (strobe.step) begin
      lineCur <= lineCur + COORD_W'(1);
    end
  end

  assign lineLast = (lineCur == lineEnd);
  assign reqRow   = ROW_W'(lineCur >> BAND_LOG2);
  assign reqCol   = COL_W'(int'(lineCur[BAND_LOG2-1:0]) * BEATS_LINE + int'(beatBase));
endmodule

// File: rtl/mcFetchCtrl.sv
module mcFetchCtrl
  import mcFetchPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkValid,
  input  logic        reqReady,
  input  logic        lineLast,
  output logic        blkReady,
  output logic        reqValid,
  output logic        done,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_ISSUE} ctrlState_t;
  ctrlState_t state;

  assign blkReady    = (state == ST_IDLE);
  assign reqValid    = (state == ST_ISSUE);
  assign strobe.load = blkReady && blkValid;
  assign strobe.step = reqValid && reqReady && !lineLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:  if (blkValid) state <= ST_ISSUE;
        default: if (reqReady && lineLast) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mcFetchPlanner.sv
module mcFetchPlanner
  import mcFetchPkg::*;
#(
  parameter int PIC_W     = 1920,
  parameter int PIC_H     = 1088,
  parameter int COORD_W   = 12,
  parameter int BUS_W     = 64,
  parameter int BAND_LOG2 = 4,
  localparam int ROW_W    = COORD_W - BAND_LOG2,
  localparam int COL_W    = BAND_LOG2 + $clog2(PIC_W / (BUS_W / 8))
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      blkValid,
  output logic                      blkReady,
  input  logic signed [COORD_W-1:0] intX,
  input  logic signed [COORD_W-1:0] intY,
  input  logic [1:0]                fracX,
  input  logic [1:0]                fracY,
  output logic                      reqValid,
  input  logic                      reqReady,
  output logic [ROW_W-1:0]          reqRow,
  output logic [COL_W-1:0]          reqCol,
  output logic [3:0]                reqBurst,
  output logic [3:0]                winRows,
  output logic [3:0]                winCols,
  output logic                      done
);
  ctrlStrobe_t strobe;
  logic lineLast;

  mcFetchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .reqReady(reqReady),
    .lineLast(lineLast), .blkReady(blkReady), .reqValid(reqValid),
    .done(done), .strobe(strobe)
  );

  mcFetchPath #(
    .PIC_W(PIC_W), .PIC_H(PIC_H), .COORD_W(COORD_W), .BUS_W(BUS_W),
    .BAND_LOG2(BAND_LOG2), .ROW_W(ROW_W), .COL_W(COL_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intX(intX), .intY(intY),
    .fracX(fracX), .fracY(fracY), .lineLast(lineLast), .reqRow(reqRow),
    .reqCol(reqCol), .reqBurst(reqBurst), .winRows(winRows), .winCols(winCols)
  );
endmodule

// File: rtl/mcFetchChecker.sv
module mcFetchChecker #(
  parameter int ROW_W = 8,
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             blkValid,
  input logic             blkReady,
  input logic             reqValid,
  input logic             reqReady,
  input logic [ROW_W-1:0] reqRow,
  input logic [COL_W-1:0] reqCol,
  input logic [3:0]       reqBurst,
  input logic [3:0]       winRows,
  input logic [3:0]       winCols,
  input logic             done
);
  logic [ROW_W-1:0] prevRow;
  logic             havePrev;
  logic [1:0]       rowSwitches;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRow     <= '0;
      havePrev    <= 1'b0;
      rowSwitches <= '0;
    end else if (blkValid && blkReady) begin
      havePrev    <= 1'b0;
      rowSwitches <= '0;
    end else if (reqValid && reqReady) begin
      prevRow  <= reqRow;
      havePrev <= 1'b1;
      if (havePrev && reqRow != prevRow && rowSwitches != 2'd3)
        rowSwitches <= rowSwitches + 2'd1;
    end
  end

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqRow) && $stable(reqCol) && $stable(reqBurst));

  a_r8_done_follows_handshake: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(reqValid && reqReady));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_burst_range: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqBurst != 4'd0 && reqBurst <= 4'd2));

  a_r2_shape_values: assert property (@(posedge clk) disable iff (!rstN)
    (winRows == 4'd4 || winRows == 4'd9) && (winCols == 4'd4 || winCols == 4'd9));

  a_r6_row_order: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && havePrev |-> reqRow >= prevRow);

  a_r6_two_rows: assert property (@(posedge clk) disable iff (!rstN)
    rowSwitches <= 2'd1);
endmodule

bind mcFetchPlanner mcFetchChecker #(.ROW_W(ROW_W), .COL_W(COL_W)) uChk (.*);

// File: tb/mcFetchPlanner_test.sv
module mcFetchPlanner_test;
  localparam int PW = 64;
  localparam int PH = 48;
  localparam int CW = 12;
  localparam int BL = 4;
  localparam int RW = CW - BL;
  localparam int LW = BL + 3;
  localparam int NV = 10;

  // x, y, fracX, fracY
  localparam int VEC [NV][4] = '{
    '{10, 5, 0, 0}, '{10, 5, 2, 0}, '{17, 20, 0, 1}, '{17, 20, 3, 3},
    '{21, 14, 0, 2}, '{-5, 2, 1, 0}, '{62, 46, 2, 2}, '{0, 0, 0, 1},
    '{-20, -20, 1, 1}, '{40, 47, 0, 0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkValid = 1'b0;
  logic reqReady = 1'b0;
  logic signed [CW-1:0] intX = '0;
  logic signed [CW-1:0] intY = '0;
  logic [1:0] fracX = '0;
  logic [1:0] fracY = '0;
  logic blkReady, reqValid, done;
  logic [RW-1:0] reqRow;
  logic [LW-1:0] reqCol;
  logic [3:0] reqBurst, winRows, winCols;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mcFetchPlanner #(.PIC_W(PW), .PIC_H(PH), .COORD_W(CW), .BUS_W(64), .BAND_LOG2(BL)) uut (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkReady(blkReady),
    .intX(intX), .intY(intY), .fracX(fracX), .fracY(fracY),
    .reqValid(reqValid), .reqReady(reqReady), .reqRow(reqRow), .reqCol(reqCol),
    .reqBurst(reqBurst), .winRows(winRows), .winCols(winCols), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampI(input int v, input int lim);
    if (v < 0) return 0;
    if (v > lim - 1) return lim - 1;
    return v;
  endfunction

  // Called at a negedge; returns at the negedge after the final handshake.
  task automatic runBlock(input int x, input int y, input int fx, input int fy, input bit stall);
    int sx = (fx != 0) ? 9 : 4;
    int sy = (fy != 0) ? 9 : 4;
    int x0 = (fx != 0) ? x - 2 : x;   // R3 origin
    int y0 = (fy != 0) ? y - 2 : y;
    int xLo = clampI(x0, PW);        // R4 clamp
    int xHi = clampI(x0 + sx - 1, PW);
    int yLo = clampI(y0, PH);
    int yHi = clampI(y0 + sy - 1, PH);
    int burst = xHi / 8 - xLo / 8 + 1;
    blkValid = 1'b1;
    intX = CW'(x); intY = CW'(y); fracX = 2'(fx); fracY = 2'(fy);
    check("R8 blkReady before accept", int'(blkReady), 1);
    @(posedge clk); @(negedge clk);
    blkValid = 1'b0;
    check("R8 done cleared after chained accept", int'(done), 0);
    check("R8 blkReady low while fetching", int'(blkReady), 0);
    check("R2 winRows", int'(winRows), sy);
    check("R2 winCols", int'(winCols), sx);
    for (int ln = yLo; ln <= yHi; ln++) begin
      if (stall && (ln % 2 == 0)) begin
        reqReady = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7 valid held during stall", int'(reqValid), 1);
      end
      reqReady = 1'b1;
      check("R9 request present", int'(reqValid), 1);
      check("R5 R6 reqRow", int'(reqRow), ln >> BL);
      check("R5 R3 reqCol", int'(reqCol), (ln % 16) * (PW / 8) + xLo / 8);
      check("R5 reqBurst", int'(reqBurst), burst);
      @(posedge clk); @(negedge clk);
      reqReady = 1'b0;
    end
    check("R8 done pulse", int'(done), 1);
    check("R8 blkReady after last", int'(blkReady), 1);
    check("R9 no extra request", int'(reqValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset blkReady", int'(blkReady), 1);
    check("R1 reset reqValid", int'(reqValid), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset winRows", int'(winRows), 4);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post reset reqValid", int'(reqValid), 0);
    check("R1 post reset winCols", int'(winCols), 4);
    for (int v = 0; v < NV; v++)
      runBlock(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v % 2 == 1);
    // idle gap: pulse ends and nothing is requested without a block
    @(negedge clk);
    check("R8 done is one cycle", int'(done), 0);
    check("R8 idle no request", int'(reqValid), 0);
    // directed corners after a gap: band crossing and bottom-right clamp
    runBlock(30, 15, 2, 1, 1'b1);
    runBlock(63, 47, 1, 3, 1'b0);
    @(negedge clk);
    check("R8 done drops after final", int'(done), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule